// File: doc/BRIEF.md
# Serial-output successive approximation sequencer

This block is the digital control of an 8-bit successive approximation converter with a synchronous serial port. An external serial clock and an active-low chip select drive the port, and both are oversampled in a faster system clock domain. Once chip select falls, the first rising serial clock edge opens a half-period track window. From the next falling edge onward the block settles one bit per falling edge against a one-bit comparator input. Each bit is placed on the serial data line as soon as it is settled, most significant bit first.

The trial code drives the external DAC. The comparator reports whether the sampled input is at or above that code. After the last decision the word can be sent a second time, starting from the least significant end. The data line is released whenever chip select is high. A new conversion can start only after the block has been returned to idle, which happens when the serial clock and chip select are both held high for a minimum number of system clock cycles. A parallel result and a done flag are brought out so the settled word can be checked directly.

Top module: `sar_serial_seq`

## Requirements
- R1: The trial code `trial` equals 1000_0000 after reset, after a select-reset and at the start of every conversion.
- R2: At each decision the bit under test keeps the comparator value (1 means input at or above the trial code), and the next lower bit is set. For an integer input `v` in 0..255, the final result equals `v`.
- R3: The first rising serial clock edge after chip select falls begins tracking. The following falling edge and the next seven falling edges each decide one bit, from bit 7 down to bit 0. Each decided bit appears on `sdo_dat` after that falling edge, and `sdo_dat` changes only after a synchronized falling edge.
- R4: With `LSB_REPLAY`=1, the seven falling edges after the bit 0 decision output result bits 1 through 7 in rising order. Bit 0 is shared between the two passes.
- R5: After the last bit of the stream, `sdo_dat` holds that bit on every further falling edge until deselect. This is bit 7 with `LSB_REPLAY`=1 and bit 0 with `LSB_REPLAY`=0.
- R6: `sdo_en` is 0 from select until the first decision and is 1 after it. It is 0 within four system clocks of chip select going high.
- R7: Holding `sclk` and `cs_n` both high for `RESET_HOLD` system clocks returns the sequencer to idle and clears `done`. A shorter overlap has no effect.
- R8: A chip select high pulse taken while `sclk` stays low does not restart a running conversion. The remaining bits follow on later falling edges.
- R9: `done` rises together with the final `result` after the eighth decision. Both then stay unchanged until a select-reset.
- R10: Asynchronous reset gives `sdo_en`=0, `done`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial converter clock |
| cs_n | input | 1 | Active-low chip select |
| comp_hi | input | 1 | Comparator: 1 when input is at or above trial |
| trial | output | WIDTH | Trial code to the DAC |
| sdo_dat | output | 1 | Serial data value |
| sdo_en | output | 1 | Serial data drive enable (0 = high impedance) |
| done | output | 1 | Conversion result valid |
| result | output | WIDTH | Parallel result |

## Verification
Several properties are checked on every cycle. The data line is released under a held deselect, and the serial bit moves only after a synchronized falling edge. The result is consistent with the trial upper bits at completion and stays stable while done is high. The done flag falls only through a select-reset, and the trial code restarts at mid-scale. The bench scenarios cover what a property cannot: the settled word for several input codes, the bit order of both passes, the held last bit for both replay settings, the short-versus-long select-reset overlap, and a conversion resumed across a deselect pulse.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CONV,
    ST_REPLAY,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic q1, q2, q3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= RST_VAL;
      q2 <= RST_VAL;
      q3 <= RST_VAL;
    end else begin
      q1 <= d;
      q2 <= q1;
      q3 <= q2;
    end
  end

  assign lvl  = q2;
  assign rise = q2 & ~q3;
  assign fall = ~q2 & q3;
endmodule

// File: rtl/sar_sel_guard.sv
module sar_sel_guard #(
  parameter int HOLD = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_hi,
  input  logic cs_hi,
  output logic soft_rst
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(HOLD);
  localparam logic [CW-1:0] CNT_FIRE = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          fire_n;
  logic          both_hi;

  assign both_hi = sclk_hi & cs_hi;

  always_comb begin
    cnt_n  = '0;
    fire_n = 1'b0;
    if (both_hi) begin
      cnt_n  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      fire_n = (cnt_q == CNT_FIRE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      soft_rst <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      soft_rst <= fire_n;
    end
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit LSB_REPLAY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             comp_hi,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             bit_q,
  output logic             valid
);
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0]    POS_MSB    = PW'(WIDTH - 1);
  localparam logic [PW-1:0]    POS_ONE    = PW'(1);
  localparam logic [WIDTH-1:0] TRIAL_INIT = {1'b1, {(WIDTH-1){1'b0}}};

  seq_state_e       st_q, st_n;
  logic [PW-1:0]    pos_q, pos_n, pos_m1;
  logic [WIDTH-1:0] trial_n, result_n;
  logic             done_n, bit_n, valid_n;

  assign pos_m1 = pos_q - 1'b1;

  always_comb begin
    st_n     = st_q;
    pos_n    = pos_q;
    trial_n  = trial;
    result_n = result;
    done_n   = done;
    bit_n    = bit_q;
    valid_n  = valid;
    if (soft_rst) begin
      st_n    = ST_IDLE;
      trial_n = TRIAL_INIT;
      done_n  = 1'b0;
      valid_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_n    = ST_ARMED;
          trial_n = TRIAL_INIT;
          done_n  = 1'b0;
          valid_n = 1'b0;
        end
        ST_ARMED: if (sclk_rise) begin
          st_n  = ST_CONV;
          pos_n = POS_MSB;
        end
        ST_CONV: if (sclk_fall) begin
          trial_n[pos_q] = comp_hi;
          if (pos_q != '0) trial_n[pos_m1] = 1'b1;
          bit_n   = comp_hi;
          valid_n = 1'b1;
          if (pos_q == '0) begin
            result_n = trial_n;
            done_n   = 1'b1;
            pos_n    = POS_ONE;
            st_n     = LSB_REPLAY ? ST_REPLAY : ST_HOLD;
          end else begin
            pos_n = pos_m1;
          end
        end
        ST_REPLAY: if (sclk_fall) begin
          bit_n = result[pos_q];
          if (pos_q == POS_MSB) st_n = ST_HOLD;
          else                  pos_n = pos_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      trial  <= TRIAL_INIT;
      result <= '0;
      done   <= 1'b0;
      bit_q  <= 1'b0;
      valid  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pos_q  <= pos_n;
      trial  <= trial_n;
      result <= result_n;
      done   <= done_n;
      bit_q  <= bit_n;
      valid  <= valid_n;
    end
  end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int WIDTH      = 8,
  parameter bit LSB_REPLAY = 1'b1,
  parameter int RESET_HOLD = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             comp_hi,
  output logic [WIDTH-1:0] trial,
  output logic             sdo_dat,
  output logic             sdo_en,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  logic rs1, rs2, rst_i;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic cs_lvl, cs_rise, cs_fall;
  logic comp_lvl, comp_rise, comp_fall;
  logic soft_rst, valid, sdo_en_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end
  assign rst_i = rs2;

  sar_edge_sync #(.RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_i), .d(sclk),
    .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

  sar_edge_sync #(.RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_i), .d(cs_n),
    .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall));

  sar_edge_sync #(.RST_VAL(1'b0)) u_comp_sync (
    .clk(clk), .rst_n(rst_i), .d(comp_hi),
    .lvl(comp_lvl), .rise(comp_rise), .fall(comp_fall));

  sar_sel_guard #(.HOLD(RESET_HOLD)) u_guard (
    .clk(clk), .rst_n(rst_i), .sclk_hi(sclk_lvl), .cs_hi(cs_lvl),
    .soft_rst(soft_rst));

  sar_engine #(.WIDTH(WIDTH), .LSB_REPLAY(LSB_REPLAY)) u_engine (
    .clk(clk), .rst_n(rst_i), .soft_rst(soft_rst), .start(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .comp_hi(comp_lvl),
    .trial(trial), .result(result), .done(done), .bit_q(sdo_dat),
    .valid(valid));

  assign sdo_en_n = valid & ~cs_lvl;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sdo_en <= 1'b0;
    else        sdo_en <= sdo_en_n;
  end

  // edges of chip select and comparator are not used beyond the level
  logic unused_edges;
  assign unused_edges = cs_rise ^ comp_rise ^ comp_fall;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sdo_en,
  input logic             sdo_dat,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic [WIDTH-1:0] trial,
  input logic             sclk_fall,
  input logic             soft_rst
);
  localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

  p_release_when_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en);

  p_result_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(result));

  p_result_matches_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (result[WIDTH-1:1] == $past(trial[WIDTH-1:1])));

  p_bit_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_dat) |-> $past(sclk_fall));

  p_done_clears_by_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(soft_rst));

  p_trial_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (trial == MID));
endmodule

bind sar_serial_seq sar_seq_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_en(sdo_en), .sdo_dat(sdo_dat),
  .done(done), .result(result), .trial(trial), .sclk_fall(sclk_fall),
  .soft_rst(soft_rst));

// File: tb/sar_serial_seq_bench.sv
`timescale 1ns/1ps
module sar_serial_seq_bench;
  localparam int W    = 8;
  localparam int HALF = 25;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n;
  logic [W-1:0] vin;
  logic [W-1:0] trial_a, result_a, trial_b, result_b;
  logic comp_a, comp_b, dat_a, dat_b, en_a, en_b, done_a, done_b;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  assign comp_a = (vin >= trial_a);
  assign comp_b = (vin >= trial_b);

  sar_serial_seq #(.WIDTH(W), .LSB_REPLAY(1'b1), .RESET_HOLD(HOLD)) u_sar_serial_seq (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .comp_hi(comp_a),
    .trial(trial_a), .sdo_dat(dat_a), .sdo_en(en_a), .done(done_a), .result(result_a));

  sar_serial_seq #(.WIDTH(W), .LSB_REPLAY(1'b0), .RESET_HOLD(HOLD)) u_noreplay (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .comp_hi(comp_b),
    .trial(trial_b), .sdo_dat(dat_b), .sdo_en(en_b), .done(done_b), .result(result_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse();
    @(negedge clk) sclk = 1'b1;
    wait_n(HALF);
    sclk = 1'b0;
    wait_n(HALF);
  endtask

  task automatic sel_reset();
    @(negedge clk) begin cs_n = 1'b1; sclk = 1'b1; end
    wait_n(HOLD + 6);
    sclk = 1'b0;
    wait_n(4);
    chk("R7 done cleared by long overlap", {31'd0, done_a}, 32'd0);
  endtask

  task automatic select();
    @(negedge clk) cs_n = 1'b0;
    wait_n(6);
  endtask

  task automatic t_async_reset();
    chk("R10 sdo_en after reset", {31'd0, en_a}, 32'd0);
    chk("R10 done after reset", {31'd0, done_a}, 32'd0);
    chk("R10 result after reset", {24'd0, result_a}, 32'd0);
    chk("R1 trial after reset", {24'd0, trial_a}, 32'h80);
  endtask

  task automatic t_convert(input logic [W-1:0] v);
    vin = v;
    sel_reset();
    chk("R1 trial after select-reset", {24'd0, trial_a}, 32'h80);
    select();
    chk("R1 trial at start", {24'd0, trial_a}, 32'h80);
    chk("R6 released before first decision", {31'd0, en_a}, 32'd0);
    for (int k = 1; k <= W; k++) begin
      sclk_pulse();
      chk("R3 msb-first bit", {31'd0, dat_a}, {31'd0, v[W-k]});
      chk("R6 driven after decision", {31'd0, en_a}, 32'd1);
      if (k < W) chk("R9 done low while converting", {31'd0, done_a}, 32'd0);
    end
    chk("R9 done after last decision", {31'd0, done_a}, 32'd1);
    chk("R2 result equals input", {24'd0, result_a}, {24'd0, v});
    chk("R2 result no-replay copy", {24'd0, result_b}, {24'd0, v});
    for (int j = 1; j < W; j++) begin
      sclk_pulse();
      chk("R4 lsb-first replay bit", {31'd0, dat_a}, {31'd0, v[j]});
      chk("R5 no-replay holds bit 0", {31'd0, dat_b}, {31'd0, v[0]});
    end
    for (int j = 0; j < 2; j++) begin
      sclk_pulse();
      chk("R5 last bit held", {31'd0, dat_a}, {31'd0, v[W-1]});
      chk("R5 no-replay still bit 0", {31'd0, dat_b}, {31'd0, v[0]});
    end
    @(negedge clk) cs_n = 1'b1;
    wait_n(6);
    chk("R6 released on deselect", {31'd0, en_a}, 32'd0);
    chk("R6 released on deselect no-replay", {31'd0, en_b}, 32'd0);
    chk("R9 done held after deselect", {31'd0, done_a}, 32'd1);
    chk("R9 result held after deselect", {24'd0, result_a}, {24'd0, v});
  endtask

  task automatic t_short_overlap();
    t_convert(8'h3C);
    @(negedge clk) sclk = 1'b1;
    wait_n(HOLD - 4);
    sclk = 1'b0;
    wait_n(6);
    chk("R7 short overlap keeps done", {31'd0, done_a}, 32'd1);
    chk("R7 short overlap keeps result", {24'd0, result_a}, 32'h3C);
    sel_reset();
    chk("R1 trial after long overlap", {24'd0, trial_a}, 32'h80);
  endtask

  task automatic t_mid_pulse();
    vin = 8'h5A;
    sel_reset();
    select();
    for (int k = 1; k <= 4; k++) begin
      sclk_pulse();
      chk("R8 bit before pulse", {31'd0, dat_a}, {31'd0, vin[W-k]});
    end
    @(negedge clk) cs_n = 1'b1;
    wait_n(10);
    chk("R8 released during pulse", {31'd0, en_a}, 32'd0);
    cs_n = 1'b0;
    wait_n(6);
    chk("R8 no restart, done still low", {31'd0, done_a}, 32'd0);
    for (int k = 5; k <= W; k++) begin
      sclk_pulse();
      chk("R8 bit resumed after pulse", {31'd0, dat_a}, {31'd0, vin[W-k]});
    end
    chk("R8 done after resumed conversion", {31'd0, done_a}, 32'd1);
    chk("R8 result after resumed conversion", {24'd0, result_a}, 32'h5A);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; vin = '0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(6);
    t_async_reset();
    t_convert(8'hA5);
    t_convert(8'h00);
    t_convert(8'hFF);
    t_convert(8'h80);
    t_convert(8'h7F);
    t_short_overlap();
    t_mid_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule